// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block watches a bank of level-sensitive interrupt request lines and picks one of them for the processor core. Each line has a 2-bit priority code that software sets through a small word-wide register port. Among the pending lines whose code is not zero, the one with the highest code wins. When several lines share that code, the line with the lowest number wins. The block then presents a 21-bit vector address, the winner's level and a valid flag, all from registers.

In the normal case the address is a table entry. A 13-bit table base forms the upper part, and the winner's number times two forms the low byte, so each table slot is two words wide. A match register can name one request number as the "fast" request. When that request wins at the top level, the address comes from a separate 21-bit fast-vector register and the table is skipped.

Register map (16-bit words, 5-bit word address): words 0 to 15 hold the priority codes, eight per word. Word 16 holds the table base. Word 17 holds the fast match number. Word 18 holds the low 16 bits of the fast vector. Word 19 holds the high 5 bits of the fast vector. Any other address reads zero.

Top module: `ivc_top`

## Requirements
- R1: After reset, every register reads zero, every priority code is 00, and `vec_valid` is low.
- R2: The priority code of request i sits at word i/8, bits [2*(i%8)+1 : 2*(i%8)]. Code 00 disables the request, so a pending request with that code never produces `vec_valid`. Codes 01, 10 and 11 give levels 0, 1 and 2, and `vec_level` reports the level of the winner (code minus one).
- R3: Among the pending enabled requests, the one with the highest level wins.
- R4: When several pending enabled requests share the highest level, the lowest-numbered one wins.
- R5: The table base register (word 16) keeps write bits 12:0. Bits 15:13 always read zero.
- R6: On the table path, `vec_addr` = {base[12:0], winner[6:0], 1'b0}.
- R7: The match register (word 17) keeps write bits 6:0. Bits 15:7 always read zero.
- R8: When the winner equals the match number and its code is 11, `vec_addr` equals the 21-bit fast-vector register.
- R9: When the winner equals the match number but its code is not 11, the table path of R6 is used.
- R10: The fast-vector register is written as word 18 (bits 15:0) and word 19 (bits 20:16 from write bits 4:0). Bits 15:5 of word 19 read zero.
- R11: The outputs are registered. A change on the request lines or in the registers shows up on `vec_valid`, `vec_level` and `vec_addr` after exactly one clock edge.
- R12: A priority word that holds no implemented request reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | N_REQ | Interrupt request lines, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| vec_valid | output | 1 | An enabled request is pending |
| vec_level | output | 2 | Level of the winner (0 to 2) |
| vec_addr | output | 21 | Vector address for the core |

## Verification
The two functions that can fall in the same cycle are the fast bypass and the priority pick. The fast request can tie at level 2 with a lower-numbered request, or it can be the match number while it is programmed below level 2. The bench raises both of these together with the fast request. A correct design gives the table address of the lower-numbered line in the tie. It gives the table address of the fast request itself when that request is below level 2. The fast vector appears only when the matched line is the sole level-2 winner. A further pattern rewrites the match number while a request is held, to show that the selection follows the register change after one edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int REG_AW     = 5;
    localparam int WORD_W     = 16;
    localparam int VEC_W      = 21;
    localparam int BASE_W     = 13;
    localparam int IDX_W      = 7;
    localparam int CODE_W     = 2;
    localparam int MAX_REQ    = 1 << IDX_W;
    localparam int FAST_HI_W  = VEC_W - WORD_W;
    localparam int CODES_PER_WORD = WORD_W / CODE_W;

    localparam logic [REG_AW-1:0] A_BASE    = 5'd16;
    localparam logic [REG_AW-1:0] A_MATCH   = 5'd17;
    localparam logic [REG_AW-1:0] A_FAST_LO = 5'd18;
    localparam logic [REG_AW-1:0] A_FAST_HI = 5'd19;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] level;
        logic [VEC_W-1:0]  addr;
    } vec_out_t;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
    import ivc_pkg::*;
#(
    parameter int N_REQ = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [REG_AW-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata,
    output logic [CODE_W*N_REQ-1:0]   codes,
    output logic [BASE_W-1:0]         base,
    output logic [IDX_W-1:0]          match,
    output logic [VEC_W-1:0]          fast_vec
);
    typedef struct packed {
        logic [CODE_W*N_REQ-1:0] codes;
        logic [BASE_W-1:0]       base;
        logic [IDX_W-1:0]        match;
        logic [VEC_W-1:0]        fast;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int i = 0; i < N_REQ; i++) begin
                if (addr == REG_AW'(i / CODES_PER_WORD))
                    st_d.codes[CODE_W*i +: CODE_W] =
                        wdata[CODE_W*(i % CODES_PER_WORD) +: CODE_W];
            end
            case (addr)
                A_BASE:    st_d.base = wdata[BASE_W-1:0];
                A_MATCH:   st_d.match = wdata[IDX_W-1:0];
                A_FAST_LO: st_d.fast[WORD_W-1:0] = wdata;
                A_FAST_HI: st_d.fast[VEC_W-1:WORD_W] = wdata[FAST_HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (addr == REG_AW'(i / CODES_PER_WORD))
                rdata[CODE_W*(i % CODES_PER_WORD) +: CODE_W] =
                    st_q.codes[CODE_W*i +: CODE_W];
        end
        case (addr)
            A_BASE:    rdata = {{(WORD_W-BASE_W){1'b0}}, st_q.base};
            A_MATCH:   rdata = {{(WORD_W-IDX_W){1'b0}}, st_q.match};
            A_FAST_LO: rdata = st_q.fast[WORD_W-1:0];
            A_FAST_HI: rdata = {{(2*WORD_W-VEC_W){1'b0}}, st_q.fast[VEC_W-1:WORD_W]};
            default: ;
        endcase
    end

    assign codes    = st_q.codes;
    assign base     = st_q.base;
    assign match    = st_q.match;
    assign fast_vec = st_q.fast;
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N_REQ = 32
) (
    input  logic [N_REQ-1:0]        req,
    input  logic [CODE_W*N_REQ-1:0] codes,
    output logic                    win_valid,
    output logic [IDX_W-1:0]        win_idx,
    output logic [CODE_W-1:0]       win_code
);
    logic [CODE_W-1:0] best_code;
    logic [IDX_W-1:0]  best_idx;

    // Scan from the top index down; ">=" lets a lower index take over a tie.
    always_comb begin
        best_code = '0;
        best_idx  = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i] && (codes[CODE_W*i +: CODE_W] != '0) &&
                (codes[CODE_W*i +: CODE_W] >= best_code)) begin
                best_code = codes[CODE_W*i +: CODE_W];
                best_idx  = IDX_W'(i);
            end
        end
    end

    assign win_valid = (best_code != '0);
    assign win_idx   = best_idx;
    assign win_code  = best_code;
endmodule

// File: rtl/ivc_vector.sv
module ivc_vector
    import ivc_pkg::*;
(
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [CODE_W-1:0] win_code,
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  match,
    input  logic [VEC_W-1:0]  fast_vec,
    output vec_out_t          vec
);
    localparam logic [CODE_W-1:0] TOP_CODE = '1;

    logic take_fast;

    always_comb begin
        take_fast  = (win_idx == match) && (win_code == TOP_CODE);
        vec.valid  = win_valid;
        vec.level  = win_valid ? win_code - CODE_W'(1) : '0;
        if (!win_valid)     vec.addr = '0;
        else if (take_fast) vec.addr = fast_vec;
        else                vec.addr = {base, win_idx, 1'b0};
    end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int N_REQ = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_REQ-1:0]     irq_req,
    input  logic                 reg_we,
    input  logic [4:0]           reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    output logic                 vec_valid,
    output logic [1:0]           vec_level,
    output logic [20:0]          vec_addr
);
    localparam int REQ_OK = (N_REQ >= 1 && N_REQ <= MAX_REQ) ? 1 : 0;

    logic [CODE_W*N_REQ-1:0] codes;
    logic [BASE_W-1:0]       base;
    logic [IDX_W-1:0]        match;
    logic [VEC_W-1:0]        fast_vec;
    logic                    win_valid;
    logic [IDX_W-1:0]        win_idx;
    logic [CODE_W-1:0]       win_code;
    vec_out_t                next_vec;
    vec_out_t                out_d, out_q;

    generate
        if (REQ_OK == 0) begin : g_bad_n
            initial $error("N_REQ out of range");
        end
    endgenerate

    ivc_regs #(.N_REQ(N_REQ)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .codes    (codes),
        .base     (base),
        .match    (match),
        .fast_vec (fast_vec)
    );

    ivc_arbiter #(.N_REQ(N_REQ)) u_arb (
        .req       (irq_req),
        .codes     (codes),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_code  (win_code)
    );

    ivc_vector u_vec (
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_code  (win_code),
        .base      (base),
        .match     (match),
        .fast_vec  (fast_vec),
        .vec       (next_vec)
    );

    always_comb begin
        out_d = next_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign vec_valid = out_q.valid;
    assign vec_level = out_q.level;
    assign vec_addr  = out_q.addr;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
    parameter int N_REQ = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] irq_req,
    input logic [4:0]       reg_addr,
    input logic [15:0]      reg_rdata,
    input logic             vec_valid,
    input logic [1:0]       vec_level,
    input logic [20:0]      vec_addr
);
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_req) |=> !vec_valid);

    assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec_level != 2'd3);

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == 21'd0 && vec_level == 2'd0);

    assert_table_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_level != 2'd2) |-> !vec_addr[0]);

    assert_base_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'd16) |-> reg_rdata[15:13] == 3'd0);

    assert_match_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'd17) |-> reg_rdata[15:7] == 9'd0);

    assert_fast_hi_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'd19) |-> reg_rdata[15:5] == 11'd0);
endmodule

bind ivc_top ivc_checker #(.N_REQ(N_REQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .vec_valid (vec_valid),
    .vec_level (vec_level),
    .vec_addr  (vec_addr)
);

// File: tb/sim_ivc_top.sv
module sim_ivc_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          vec_valid;
    logic [1:0]    vec_level;
    logic [20:0]   vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ivc_top #(.N_REQ(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_valid(vec_valid), .vec_level(vec_level), .vec_addr(vec_addr)
    );

    // {req, valid, level, addr}; base 0x1ABC, match 9, fast 0x12345
    localparam int NV = 10;
    localparam logic [55:0] VEC [NV] = '{
        {32'h0000_0000, 1'b0, 2'd0, 21'h000000},  // R1 nothing pending
        {32'h0000_0001, 1'b1, 2'd0, 21'h1ABC00},  // R6 req0
        {32'h0000_0003, 1'b1, 2'd1, 21'h1ABC02},  // R3 req1 over req0
        {32'h0000_000A, 1'b1, 2'd1, 21'h1ABC02},  // R4 tie 1,3
        {32'h0000_0008, 1'b1, 2'd1, 21'h1ABC06},  // R6 req3
        {32'h0000_0020, 1'b0, 2'd0, 21'h000000},  // R2 req5 disabled
        {32'h0000_0204, 1'b1, 2'd2, 21'h1ABC04},  // R4 tie 2,9 fast loses
        {32'h0000_0200, 1'b1, 2'd2, 21'h012345},  // R8 fast
        {32'h8000_0020, 1'b1, 2'd0, 21'h1ABC3E},  // R6 req31
        {32'hFFFF_FFFF, 1'b1, 2'd2, 21'h1ABC04}   // R3 all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        check(req, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    task automatic apply(input logic [31:0] r);
        @(negedge clk);
        irq_req = r;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 valid", {31'd0, vec_valid}, 32'd0);
        for (int a = 0; a < 20; a++) rd("R1 reg", 5'(a), 16'h0000);
        // R2 all codes 00: pending requests ignored
        apply(32'hFFFF_FFFF);
        check("R2 disabled", {31'd0, vec_valid}, 32'd0);
        apply(32'h0);

        // setup: req0=01 req1=10 req2=11 req3=10 req5=00; word0
        wr(5'd0, 16'b00_00_00_00_10_11_10_01);
        wr(5'd1, 16'b0000_0000_0000_1100);   // req9 = 11
        wr(5'd3, 16'b01_00_00_00_00_00_00_00); // req31 = 01
        wr(5'd16, 16'h1ABC);
        wr(5'd17, 16'd9);
        wr(5'd18, 16'h2345);
        wr(5'd19, 16'h0001);
        rd("R2 word0", 5'd0, 16'b0000_0000_1011_1001);
        rd("R2 word3", 5'd3, 16'h4000);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][55:24]);
            check("R3/R4/R6/R8 valid", {31'd0, vec_valid}, {31'd0, VEC[k][23]});
            check("R2 level", {30'd0, vec_level}, {30'd0, VEC[k][22:21]});
            check("R6/R8 addr", {11'd0, vec_addr}, {11'd0, VEC[k][20:0]});
        end

        // R11 latency: change seen only after one edge
        apply(32'h0);
        @(negedge clk);
        irq_req = 32'h0000_0001;
        #0.5;
        check("R11 before edge", {31'd0, vec_valid}, 32'd0);
        @(negedge clk);
        check("R11 after edge", {31'd0, vec_valid}, 32'd1);

        // R9 match on a level-1 request uses table
        irq_req = 32'h0000_0008;
        wr(5'd17, 16'd3);
        check("R9 table", {11'd0, vec_addr}, {11'd0, 21'h1ABC06});
        // lower req9 to level1 with match 9: table path
        wr(5'd17, 16'd9);
        wr(5'd1, 16'b0000_0000_0000_1000);
        apply(32'h0000_0200);
        check("R9 level1 match", {11'd0, vec_addr}, {11'd0, 21'h1ABC12});
        check("R9 level", {30'd0, vec_level}, 32'd1);

        // R5/R7/R10 write masks
        wr(5'd16, 16'hFFFF); rd("R5 base", 5'd16, 16'h1FFF);
        wr(5'd17, 16'hFFFF); rd("R7 match", 5'd17, 16'h007F);
        wr(5'd19, 16'hFFFF); rd("R10 fast hi", 5'd19, 16'h001F);
        wr(5'd18, 16'hBEEF); rd("R10 fast lo", 5'd18, 16'hBEEF);
        // R12 unimplemented priority word
        wr(5'd4, 16'hFFFF); rd("R12 word4", 5'd4, 16'h0000);
        wr(5'd20, 16'hFFFF); rd("R12 unmapped", 5'd20, 16'h0000);

        // R8 with new values: base 0x1FFF, match 127 unused; fast 0x1FBEEF
        wr(5'd17, 16'd2);
        apply(32'h0000_0004);
        check("R8 fast new", {11'd0, vec_addr}, {11'd0, 21'h1FBEEF});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule